// File: doc/BRIEF.md
# Pipelined Ratio Threshold Comparator

This block decides whether the ratio of a numerator energy sum to a denominator energy sum is larger than a programmable threshold. It does not divide. It multiplies the denominator by the threshold and checks that product against the numerator. The test `threshold < N / D` therefore becomes `D * threshold < N`.

The datapath is laid out like a multiply-accumulate slice:

- An optional pre-adder can form the denominator from two partial sums.
- A 25-by-18 unsigned multiplier follows the pre-adder.
- A 48-bit compare stage closes the pipeline.

The block takes one input set on every clock with no stall. It returns a pass flag together with a valid strobe exactly three cycles later, in input order.

Top module: `ratio_thresh_cmp`

## Requirements
- R1: While `rstN` is low, and until the first result leaves the pipeline, `outValid` and `passFlag` are 0.
- R2: For each accepted input set, `passFlag` is 1 exactly when the unsigned product of the denominator D and `threshold` is less than `numSum`. The full 43-bit product and the zero-extended numerator are compared at 48 bits.
- R3: The comparison is strict: a product equal to `numSum` gives `passFlag` = 0.
- R4: `outValid` rises on the third rising edge after the edge that captured `inValid` = 1. Every accepted set yields exactly one result, in order, including for back-to-back sets with no idle cycles.
- R5: When D is zero, `passFlag` is 1 if `numSum` is non-zero and 0 if `numSum` is zero.
- R6: In cycles where `outValid` is 0, `passFlag` keeps its previous value. Input values presented while `inValid` is 0 never change a result.
- R7: With `preAddSel` = 1, D is `denA + denB`, formed at 25 bits so that the carry is kept.
- R8: With `preAddSel` = 0, D is `denA` alone, and `denB` has no effect on the result.
- R9: Full-scale operands produce correct results with no truncation: all-ones 24-bit denominators, an all-ones 18-bit threshold and an all-ones 32-bit numerator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input set is valid this cycle |
| numSum | input | 32 | Numerator energy sum N, unsigned |
| denA | input | 24 | First denominator partial sum, unsigned |
| denB | input | 24 | Second denominator partial sum, unsigned |
| preAddSel | input | 1 | 1: D = denA + denB, 0: D = denA |
| threshold | input | 18 | Ratio threshold, unsigned integer |
| outValid | output | 1 | Result valid, three cycles after input |
| passFlag | output | 1 | 1 when threshold < N / D (cross-multiplied form) |

## Verification
The bound checker checks the following on every cycle:

- The three-cycle alignment of `outValid` with `inValid`.
- The value of every emitted flag against a model of the cross-multiplied test, built from inputs delayed by three cycles.
- The zero-denominator rule.
- That the flag is held while no result is emitted.
- That the outputs are zero during reset.

Some corner cases show up only in the bench's directed scenarios. These are the exact boundary where the product equals the numerator, the carry out of the pre-adder, the independence from `denB` when the pre-adder is bypassed, and full-scale operands. The same holds for result ordering in a long back-to-back stream with random idle gaps and junk values on the inputs.

// File: rtl/ratio_cmp_pkg.sv
package ratio_cmp_pkg;

  // Per-stage load strobes issued by the control to the datapath.
  typedef struct packed {
    logic ldPre;   // capture pre-adder result and operand copies
    logic ldMul;   // capture product
    logic ldCmp;   // capture compare result
  } stageStrobe_t;

  localparam int PIPE_DEPTH = 3;

endpackage

// File: rtl/ratio_cmp_ctrl.sv
module ratio_cmp_ctrl
  import ratio_cmp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stageStrobe_t strobes,
  output logic         outValid
);

  logic [PIPE_DEPTH-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[PIPE_DEPTH-2:0], inValid};
    end
  end

  always_comb begin
    strobes.ldPre = inValid;
    strobes.ldMul = validPipe[0];
    strobes.ldCmp = validPipe[1];
  end

  assign outValid = validPipe[PIPE_DEPTH-1];

endmodule

// File: rtl/ratio_cmp_datapath.sv
module ratio_cmp_datapath
  import ratio_cmp_pkg::*;
#(
  parameter int NUM_W   = 32,
  parameter int DEN_W   = 24,
  parameter int THR_W   = 18,
  parameter int ACC_W   = 48,
  parameter bit PRE_ADD = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  stageStrobe_t     strobes,
  input  logic [NUM_W-1:0] numSum,
  input  logic [DEN_W-1:0] denA,
  input  logic [DEN_W-1:0] denB,
  input  logic             preAddSel,
  input  logic [THR_W-1:0] threshold,
  output logic             passFlag
);

  localparam int MULA_W = DEN_W + 1;        // pre-adder keeps its carry
  localparam int PROD_W = MULA_W + THR_W;   // full product width

  // Stage 1: pre-adder
  logic [MULA_W-1:0] preSumNext;
  logic [MULA_W-1:0] preSumQ;
  logic [THR_W-1:0]  thrQ;
  logic [NUM_W-1:0]  numQ1;

  generate
    if (PRE_ADD) begin : g_preAdd
      always_comb begin
        if (preAddSel) preSumNext = MULA_W'(denA) + MULA_W'(denB);
        else           preSumNext = MULA_W'(denA);
      end
    end else begin : g_noPreAdd
      logic unusedSel;
      logic [DEN_W-1:0] unusedB;
      assign unusedSel  = preAddSel;
      assign unusedB    = denB;
      assign preSumNext = MULA_W'(denA);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preSumQ <= '0;
      thrQ    <= '0;
      numQ1   <= '0;
    end else if (strobes.ldPre) begin
      preSumQ <= preSumNext;
      thrQ    <= threshold;
      numQ1   <= numSum;
    end
  end

  // Stage 2: multiplier
  logic [PROD_W-1:0] prodNext;
  logic [PROD_W-1:0] prodQ;
  logic [NUM_W-1:0]  numQ2;

  assign prodNext = PROD_W'(preSumQ) * PROD_W'(thrQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodQ <= '0;
      numQ2 <= '0;
    end else if (strobes.ldMul) begin
      prodQ <= prodNext;
      numQ2 <= numQ1;
    end
  end

  // Stage 3: 48-bit strict compare
  logic [ACC_W-1:0] accProd;
  logic [ACC_W-1:0] accNum;
  logic             ltNext;

  assign accProd = ACC_W'(prodQ);
  assign accNum  = ACC_W'(numQ2);
  assign ltNext  = accProd < accNum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passFlag <= 1'b0;
    end else if (strobes.ldCmp) begin
      passFlag <= ltNext;
    end
  end

endmodule

// File: rtl/ratio_thresh_cmp.sv
module ratio_thresh_cmp
  import ratio_cmp_pkg::*;
#(
  parameter int NUM_W   = 32,
  parameter int DEN_W   = 24,
  parameter int THR_W   = 18,
  parameter int ACC_W   = 48,
  parameter bit PRE_ADD = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [NUM_W-1:0] numSum,
  input  logic [DEN_W-1:0] denA,
  input  logic [DEN_W-1:0] denB,
  input  logic             preAddSel,
  input  logic [THR_W-1:0] threshold,
  output logic             outValid,
  output logic             passFlag
);

  stageStrobe_t strobes;

  ratio_cmp_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  ratio_cmp_datapath #(
    .NUM_W   (NUM_W),
    .DEN_W   (DEN_W),
    .THR_W   (THR_W),
    .ACC_W   (ACC_W),
    .PRE_ADD (PRE_ADD)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .numSum    (numSum),
    .denA      (denA),
    .denB      (denB),
    .preAddSel (preAddSel),
    .threshold (threshold),
    .passFlag  (passFlag)
  );

endmodule

// File: rtl/ratio_thresh_cmp_chk.sv
module ratio_thresh_cmp_chk #(
  parameter int NUM_W   = 32,
  parameter int DEN_W   = 24,
  parameter int THR_W   = 18,
  parameter int ACC_W   = 48,
  parameter bit PRE_ADD = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [NUM_W-1:0] numSum,
  input logic [DEN_W-1:0] denA,
  input logic [DEN_W-1:0] denB,
  input logic             preAddSel,
  input logic [THR_W-1:0] threshold,
  input logic             outValid,
  input logic             passFlag
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  function automatic logic modelPass(input logic [NUM_W-1:0] n,
                                     input logic [DEN_W-1:0] a,
                                     input logic [DEN_W-1:0] b,
                                     input logic             sel,
                                     input logic [THR_W-1:0] t);
    logic [ACC_W-1:0] d;
    d = (PRE_ADD && sel) ? ACC_W'(a) + ACC_W'(b) : ACC_W'(a);
    return (d * ACC_W'(t)) < ACC_W'(n);
  endfunction

  logic denZero;
  assign denZero = (denA == '0) && (!(PRE_ADD && preAddSel) || denB == '0);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!outValid && !passFlag)); // R1

  AST_LATENCY_THREE: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3))); // R4

  AST_EARLY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd3) |-> !outValid); // R1

  AST_PASS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outValid) |->
      (passFlag == $past(modelPass(numSum, denA, denB, preAddSel, threshold), 3))); // R2

  AST_ZERO_DEN: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outValid && $past(denZero, 3)) |->
      (passFlag == ($past(numSum, 3) != '0))); // R5

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && !outValid) |-> $stable(passFlag)); // R6

endmodule

bind ratio_thresh_cmp ratio_thresh_cmp_chk #(
  .NUM_W   (NUM_W),
  .DEN_W   (DEN_W),
  .THR_W   (THR_W),
  .ACC_W   (ACC_W),
  .PRE_ADD (PRE_ADD)
) chk_i (.*);

// File: tb/ratio_thresh_cmp_tb_top.sv
module ratio_thresh_cmp_tb_top;

  localparam int NUM_W = 32;
  localparam int DEN_W = 24;
  localparam int THR_W = 18;

  logic             clk = 1'b0;
  logic             rstN = 1'b1;
  logic             inValid = 1'b0;
  logic [NUM_W-1:0] numSum = '0;
  logic [DEN_W-1:0] denA = '0;
  logic [DEN_W-1:0] denB = '0;
  logic             preAddSel = 1'b0;
  logic [THR_W-1:0] threshold = '0;
  logic             outValid;
  logic             passFlag;

  always #5 clk = ~clk;

  ratio_thresh_cmp dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .numSum(numSum),
    .denA(denA), .denB(denB), .preAddSel(preAddSel), .threshold(threshold),
    .outValid(outValid), .passFlag(passFlag)
  );

  typedef struct {
    logic  expFlag;
    int    dueCycle;
    string req;
  } sbItem_t;

  sbItem_t sbq[$];
  int  cycle = 0;
  int  nRun = 0;
  int  nFail = 0;
  bit  monOn = 1'b0;
  bit  done = 1'b0;
  logic lastFlag = 1'b0;

  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic refPass(input longint n, input longint a, input longint b,
                                   input bit sel, input longint t);
    longint d;
    d = sel ? a + b : a;
    return (d * t) < n;
  endfunction

  task automatic send(input longint n, input longint a, input longint b,
                      input bit sel, input longint t, input string req);
    sbItem_t it;
    @(negedge clk);
    inValid   = 1'b1;
    numSum    = NUM_W'(n);
    denA      = DEN_W'(a);
    denB      = DEN_W'(b);
    preAddSel = sel;
    threshold = THR_W'(t);
    it.expFlag  = refPass(n, a, b, sel, t);
    it.dueCycle = cycle + 3;
    it.req      = req;
    sbq.push_back(it);
  endtask

  // Idle cycles with junk on the data inputs (R6: ignored while invalid)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid   = 1'b0;
      numSum    = NUM_W'($urandom);
      denA      = DEN_W'($urandom);
      denB      = DEN_W'($urandom);
      preAddSel = 1'(($urandom) & 1);
      threshold = THR_W'($urandom);
    end
  endtask

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (monOn && rstN) begin
      if (outValid) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R4", "unexpected outValid", 1, 0);
        end else begin
          sbItem_t it;
          it = sbq.pop_front();
          check(cycle == it.dueCycle, "R4", "result cycle", cycle, it.dueCycle);
          check(passFlag == it.expFlag, it.req, "passFlag", passFlag, it.expFlag);
        end
      end else begin
        check(passFlag == lastFlag, "R6", "flag held while idle", passFlag, lastFlag);
      end
      lastFlag = passFlag;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nRun++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycle, 0);
    finish_run();
  end

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    check(passFlag == 1'b0, "R1", "passFlag in reset", passFlag, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    check(passFlag == 1'b0, "R1", "passFlag after reset", passFlag, 0);
    lastFlag = passFlag;
    monOn = 1'b1;

    // R3: equality boundary, then one above
    send(500, 100, 0, 1'b0, 5, "R3");
    send(501, 100, 0, 1'b0, 5, "R3");
    send(499, 100, 0, 1'b0, 5, "R2");
    idle(4);
    // R7: pre-adder forms the denominator, including carry out of 24 bits
    send(500, 60, 40, 1'b1, 5, "R7");
    send(501, 60, 40, 1'b1, 5, "R7");
    send(64'd33554431, 64'hFFFFFF, 64'hFFFFFF, 1'b1, 1, "R7");
    send(64'd33554429, 64'hFFFFFF, 64'hFFFFFF, 1'b1, 1, "R7");
    idle(2);
    // R8: denB ignored when pre-adder bypassed
    send(301, 60, 999999, 1'b0, 5, "R8");
    send(300, 60, 16777215, 1'b0, 5, "R8");
    idle(3);
    // R5: zero denominator
    send(1, 0, 0, 1'b1, 262143, "R5");
    send(0, 0, 0, 1'b1, 262143, "R5");
    send(3, 0, 7, 1'b0, 100, "R5");
    send(0, 0, 7, 1'b0, 100, "R5");
    idle(1);
    // R9: full scale, no truncation
    send(64'hFFFFFFFF, 64'hFFFFFF, 64'hFFFFFF, 1'b1, 64'h3FFFF, "R9");
    send(64'h40000, 1, 0, 1'b0, 64'h3FFFF, "R9");
    send(64'h3FFFF, 1, 0, 1'b0, 64'h3FFFF, "R9");
    send(64'hFFFFFFFF, 64'h4000, 0, 1'b0, 64'h3FFFF, "R9");
    send(64'hFFFFFFFF, 64'h3FFF, 0, 1'b0, 64'h3FFFF, "R9");
    idle(5);
    // R2/R4: random stream, back-to-back with random gaps
    for (int i = 0; i < 300; i++) begin
      longint t;
      longint a;
      longint b;
      longint n;
      bit s;
      a = longint'($urandom) & 64'hFFF;
      b = longint'($urandom) & 64'hFFF;
      s = 1'(($urandom) & 1);
      t = longint'($urandom) & 64'hFF;
      n = (s ? a + b : a) * t + longint'($urandom_range(0, 4)) - 2;
      if (n < 0) n = 0;
      send(n, a, b, s, t, "R2");
      if (($urandom & 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(8);
    check(sbq.size() == 0, "R4", "all results emitted", sbq.size(), 0);
    finish_run();
  end

endmodule